// File: doc/BRIEF.md
# Bus Master Domain Assignment Unit

This unit labels each bus transaction with a domain identifier and with the effective privilege and security attributes that later access checks use. The transaction carries an identity word. The unit compares that word at the same time against every entry in a bank of programmable descriptors.

Each descriptor holds the following fields:
- an enable flag
- a compare value
- a don't-care mask
- a domain number
- two 2-bit attribute modes
- a lock flag

If several descriptors match, the one with the lowest index decides the result. All results are registered and appear one clock after the request.

A single-beat write port loads one complete descriptor per cycle. A descriptor written with its lock flag set is frozen until the next reset. Both attribute mode fields use the same encoding:

| Code | Effect |
|------|--------|
| 2'b00 | pass the incoming bit through |
| 2'b01 | reserved, also passes the bit through |
| 2'b10 | force the bit to 0 |
| 2'b11 | force the bit to 1 |

For the privilege output, 1 means privileged and 0 means user. For the security output, 1 means secure and 0 means non-secure.

The unit has no state machine. It is a parallel compare, then a priority pick, then one output register stage.

Top module: `mda_assign_unit`

## Requirements
- R1: After reset, `out_valid`, `out_hit` and `out_did` are 0, and every descriptor is disabled and unlocked, so the first lookup misses.
- R2: A descriptor whose enable flag is 0 never produces a hit, even when its compare value matches.
- R3: A descriptor hits when `((req_id ^ match) & ~mask) == 0`. A mask bit of 1 makes that identity bit don't-care.
- R4: When several descriptors hit, the one with the lowest index wins.
- R5: On a hit, `out_did` equals the domain number of the winning descriptor.
- R6: On a hit, `out_priv` follows the winner's privilege mode. 00 and 01 pass `req_priv` through, 10 gives 0 (user) and 11 gives 1 (privileged).
- R7: On a hit, `out_sec` follows the winner's security mode. 00 and 01 pass `req_sec` through, 10 gives 0 (non-secure) and 11 gives 1 (secure).
- R8: On a miss, `out_hit` is 0, `out_did` is 0, and `out_priv` and `out_sec` equal `req_priv` and `req_sec`.
- R9: `out_valid` equals `req_valid` delayed by one clock. While `req_valid` is 0, the result outputs hold their values.
- R10: A write with `cfg_lock`=1 to an unlocked descriptor stores all of its fields and locks it. Writes to a locked descriptor change nothing until reset.
- R11: A write and a lookup in the same cycle are ordered: the lookup uses the descriptor contents from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | IDX_W | Index of the descriptor to write |
| cfg_valid | input | 1 | Enable flag to store |
| cfg_match | input | ID_W | Compare value to store |
| cfg_mask | input | ID_W | Don't-care mask to store |
| cfg_did | input | DID_W | Domain number to store |
| cfg_priv_mode | input | 2 | Privilege mode to store |
| cfg_sec_mode | input | 2 | Security mode to store |
| cfg_lock | input | 1 | Lock flag to store |
| req_valid | input | 1 | Transaction present |
| req_id | input | ID_W | Transaction identity word |
| req_priv | input | 1 | Incoming privilege (1 = privileged) |
| req_sec | input | 1 | Incoming security (1 = secure) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_did | output | DID_W | Assigned domain number |
| out_priv | output | 1 | Effective privilege |
| out_sec | output | 1 | Effective security |
| out_hit | output | 1 | A descriptor matched |

## Verification
A descriptor write and a lookup can fall in the same cycle, and this is the case that matters most. The bench raises `cfg_we` and `req_valid` together, loading descriptor 6 with a compare value equal to the request's identity. It expects that result to be a miss, because the lookup sees the old contents. A lookup with the same identity in the following cycle must then hit with the new domain number. Locked writes, invalidations and resets are interleaved with lookups in the same way, and each is judged only at the result port.

// File: rtl/mda_pkg.sv
package mda_pkg;

    typedef enum logic [1:0] {
        MODE_PASS = 2'b00,
        MODE_RSVD = 2'b01,
        MODE_LOW  = 2'b10,
        MODE_HIGH = 2'b11
    } attr_mode_e;

    // Resolve one attribute bit from a 2-bit mode field and the incoming value.
    function automatic logic apply_mode(input attr_mode_e mode, input logic in_bit);
        logic res;
        unique case (mode)
            MODE_LOW:  res = 1'b0;
            MODE_HIGH: res = 1'b1;
            default:   res = in_bit;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/mda_desc_bank.sv
module mda_desc_bank #(
    parameter  int NUM_DESC = 8,
    parameter  int ID_W     = 8,
    parameter  int DID_W    = 4,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic                            wr_valid,
    input  logic [ID_W-1:0]                 wr_match,
    input  logic [ID_W-1:0]                 wr_mask,
    input  logic [DID_W-1:0]                wr_did,
    input  logic [1:0]                      wr_priv,
    input  logic [1:0]                      wr_sec,
    input  logic                            wr_lock,
    output logic [NUM_DESC-1:0]             valid_vec,
    output logic [NUM_DESC-1:0]             lock_vec,
    output logic [NUM_DESC-1:0][ID_W-1:0]   match_arr,
    output logic [NUM_DESC-1:0][ID_W-1:0]   mask_arr,
    output logic [NUM_DESC-1:0][DID_W-1:0]  did_arr,
    output logic [NUM_DESC-1:0][1:0]        priv_arr,
    output logic [NUM_DESC-1:0][1:0]        sec_arr
);

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_entry
        logic             ent_valid;
        logic             ent_lock;
        logic [ID_W-1:0]  ent_match;
        logic [ID_W-1:0]  ent_mask;
        logic [DID_W-1:0] ent_did;
        logic [1:0]       ent_priv;
        logic [1:0]       ent_sec;
        logic             ent_sel;

        // A locked entry ignores the write strobe entirely.
        assign ent_sel = wr_en && (wr_idx == IDX_W'(i)) && !ent_lock;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_valid <= 1'b0;
                ent_lock  <= 1'b0;
                ent_match <= '0;
                ent_mask  <= '0;
                ent_did   <= '0;
                ent_priv  <= 2'b00;
                ent_sec   <= 2'b00;
            end else if (ent_sel) begin
                ent_valid <= wr_valid;
                ent_lock  <= wr_lock;
                ent_match <= wr_match;
                ent_mask  <= wr_mask;
                ent_did   <= wr_did;
                ent_priv  <= wr_priv;
                ent_sec   <= wr_sec;
            end
        end

        assign valid_vec[i] = ent_valid;
        assign lock_vec[i]  = ent_lock;
        assign match_arr[i] = ent_match;
        assign mask_arr[i]  = ent_mask;
        assign did_arr[i]   = ent_did;
        assign priv_arr[i]  = ent_priv;
        assign sec_arr[i]   = ent_sec;
    end

endmodule

// File: rtl/mda_match.sv
module mda_match #(
    parameter int NUM_DESC = 8,
    parameter int ID_W     = 8
) (
    input  logic [ID_W-1:0]               id_in,
    input  logic [NUM_DESC-1:0]           valid_vec,
    input  logic [NUM_DESC-1:0][ID_W-1:0] match_arr,
    input  logic [NUM_DESC-1:0][ID_W-1:0] mask_arr,
    output logic [NUM_DESC-1:0]           hit_vec
);

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_cmp
        logic [ID_W-1:0] diff;

        // Differing bits count only where the mask does not mark don't-care.
        assign diff       = (id_in ^ match_arr[i]) & ~mask_arr[i];
        assign hit_vec[i] = valid_vec[i] && (diff == '0);
    end

endmodule

// File: rtl/mda_prio_pick.sv
module mda_prio_pick #(
    parameter  int NUM_DESC = 8,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic [NUM_DESC-1:0] hit_vec,
    output logic                any_hit,
    output logic [IDX_W-1:0]    win_idx
);

    // Scan from the top down so the lowest set index is the last assignment.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = NUM_DESC - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mda_assign_unit.sv
module mda_assign_unit
    import mda_pkg::*;
#(
    parameter  int NUM_DESC = 8,
    parameter  int ID_W     = 8,
    parameter  int DID_W    = 4,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_valid,
    input  logic [ID_W-1:0]  cfg_match,
    input  logic [ID_W-1:0]  cfg_mask,
    input  logic [DID_W-1:0] cfg_did,
    input  logic [1:0]       cfg_priv_mode,
    input  logic [1:0]       cfg_sec_mode,
    input  logic             cfg_lock,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_id,
    input  logic             req_priv,
    input  logic             req_sec,
    output logic             out_valid,
    output logic [DID_W-1:0] out_did,
    output logic             out_priv,
    output logic             out_sec,
    output logic             out_hit
);

    logic [NUM_DESC-1:0]            valid_vec;
    logic [NUM_DESC-1:0]            lock_vec;
    logic [NUM_DESC-1:0][ID_W-1:0]  match_arr;
    logic [NUM_DESC-1:0][ID_W-1:0]  mask_arr;
    logic [NUM_DESC-1:0][DID_W-1:0] did_arr;
    logic [NUM_DESC-1:0][1:0]       priv_arr;
    logic [NUM_DESC-1:0][1:0]       sec_arr;
    logic [NUM_DESC-1:0]            hit_vec;
    logic                           any_hit;
    logic [IDX_W-1:0]               win_idx;

    logic [DID_W-1:0]               nxt_did;
    logic                           nxt_priv;
    logic                           nxt_sec;

    mda_desc_bank #(
        .NUM_DESC (NUM_DESC),
        .ID_W     (ID_W),
        .DID_W    (DID_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_valid  (cfg_valid),
        .wr_match  (cfg_match),
        .wr_mask   (cfg_mask),
        .wr_did    (cfg_did),
        .wr_priv   (cfg_priv_mode),
        .wr_sec    (cfg_sec_mode),
        .wr_lock   (cfg_lock),
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec),
        .match_arr (match_arr),
        .mask_arr  (mask_arr),
        .did_arr   (did_arr),
        .priv_arr  (priv_arr),
        .sec_arr   (sec_arr)
    );

    mda_match #(
        .NUM_DESC (NUM_DESC),
        .ID_W     (ID_W)
    ) u_match (
        .id_in     (req_id),
        .valid_vec (valid_vec),
        .match_arr (match_arr),
        .mask_arr  (mask_arr),
        .hit_vec   (hit_vec)
    );

    mda_prio_pick #(
        .NUM_DESC (NUM_DESC)
    ) u_pick (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    always_comb begin
        if (any_hit) begin
            nxt_did  = did_arr[win_idx];
            nxt_priv = apply_mode(attr_mode_e'(priv_arr[win_idx]), req_priv);
            nxt_sec  = apply_mode(attr_mode_e'(sec_arr[win_idx]), req_sec);
        end else begin
            nxt_did  = '0;
            nxt_priv = req_priv;
            nxt_sec  = req_sec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_did   <= '0;
            out_priv  <= 1'b0;
            out_sec   <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_hit  <= any_hit;
                out_did  <= nxt_did;
                out_priv <= nxt_priv;
                out_sec  <= nxt_sec;
            end
        end
    end

endmodule

// File: rtl/mda_assign_checker.sv
module mda_assign_checker #(
    parameter int NUM_DESC = 8,
    parameter int DID_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_priv,
    input logic                req_sec,
    input logic                out_valid,
    input logic [DID_W-1:0]    out_did,
    input logic                out_priv,
    input logic                out_sec,
    input logic                out_hit,
    input logic [NUM_DESC-1:0] valid_vec,
    input logic [NUM_DESC-1:0] lock_vec
);

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_did) && $stable(out_hit)));

    p_miss_zero_did_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_did == '0));

    p_miss_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_hit || (out_priv == $past(req_priv) && out_sec == $past(req_sec))));

    p_disabled_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && valid_vec == '0) |=> !out_hit);

    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lock_vec & $past(lock_vec)) == $past(lock_vec)));

endmodule

bind mda_assign_unit mda_assign_checker #(
    .NUM_DESC (NUM_DESC),
    .DID_W    (DID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_priv  (req_priv),
    .req_sec   (req_sec),
    .out_valid (out_valid),
    .out_did   (out_did),
    .out_priv  (out_priv),
    .out_sec   (out_sec),
    .out_hit   (out_hit),
    .valid_vec (valid_vec),
    .lock_vec  (lock_vec)
);

// File: tb/mda_assign_unit_test.sv
`timescale 1ns/1ps
module mda_assign_unit_test;

    localparam int NUM_DESC = 8;
    localparam int ID_W     = 8;
    localparam int DID_W    = 4;
    localparam int IDX_W    = 3;
    localparam int NVEC     = 10;

    // Vector: {id[8], priv_in, sec_in, exp_hit, exp_did[4], exp_priv, exp_sec}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'hA7, 1'b0, 1'b1, 1'b1, 4'd3,  1'b1, 1'b0},
        {8'hA5, 1'b0, 1'b0, 1'b1, 4'd3,  1'b1, 1'b0},
        {8'h30, 1'b1, 1'b0, 1'b1, 4'd9,  1'b1, 1'b0},
        {8'h50, 1'b0, 1'b1, 1'b1, 4'd9,  1'b0, 1'b1},
        {8'h81, 1'b0, 1'b0, 1'b1, 4'd12, 1'b1, 1'b1},
        {8'h80, 1'b1, 1'b1, 1'b1, 4'd9,  1'b1, 1'b1},
        {8'h82, 1'b1, 1'b0, 1'b0, 4'd0,  1'b1, 1'b0},
        {8'h7F, 1'b0, 1'b1, 1'b0, 4'd0,  1'b0, 1'b1},
        {8'hAF, 1'b1, 1'b1, 1'b1, 4'd3,  1'b1, 1'b0},
        {8'hB0, 1'b0, 1'b0, 1'b1, 4'd9,  1'b0, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_we;
    logic [IDX_W-1:0] cfg_idx;
    logic             cfg_valid;
    logic [ID_W-1:0]  cfg_match;
    logic [ID_W-1:0]  cfg_mask;
    logic [DID_W-1:0] cfg_did;
    logic [1:0]       cfg_priv_mode;
    logic [1:0]       cfg_sec_mode;
    logic             cfg_lock;
    logic             req_valid;
    logic [ID_W-1:0]  req_id;
    logic             req_priv;
    logic             req_sec;
    logic             out_valid;
    logic [DID_W-1:0] out_did;
    logic             out_priv;
    logic             out_sec;
    logic             out_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mda_assign_unit #(
        .NUM_DESC (NUM_DESC),
        .ID_W     (ID_W),
        .DID_W    (DID_W)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_idx       (cfg_idx),
        .cfg_valid     (cfg_valid),
        .cfg_match     (cfg_match),
        .cfg_mask      (cfg_mask),
        .cfg_did       (cfg_did),
        .cfg_priv_mode (cfg_priv_mode),
        .cfg_sec_mode  (cfg_sec_mode),
        .cfg_lock      (cfg_lock),
        .req_valid     (req_valid),
        .req_id        (req_id),
        .req_priv      (req_priv),
        .req_sec       (req_sec),
        .out_valid     (out_valid),
        .out_did       (out_did),
        .out_priv      (out_priv),
        .out_sec       (out_sec),
        .out_hit       (out_hit)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put_desc(input int idx, input logic v, input logic [7:0] m,
                            input logic [7:0] k, input logic [3:0] d,
                            input logic [1:0] pm, input logic [1:0] sm, input logic lk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_valid = v; cfg_match = m;
        cfg_mask = k; cfg_did = d; cfg_priv_mode = pm; cfg_sec_mode = sm; cfg_lock = lk;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive a request at a falling edge; result is registered at the next rising edge.
    task automatic look(input logic [7:0] id, input logic p, input logic s);
        @(negedge clk);
        req_valid = 1'b1; req_id = id; req_priv = p; req_sec = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        cfg_we = 1'b0; cfg_idx = '0; cfg_valid = 1'b0; cfg_match = '0; cfg_mask = '0;
        cfg_did = '0; cfg_priv_mode = 2'b00; cfg_sec_mode = 2'b00; cfg_lock = 1'b0;
        req_valid = 1'b0; req_id = '0; req_priv = 1'b0; req_sec = 1'b0;
        do_reset();

        // R1 reset state
        @(negedge clk);
        cmp("R1 out_valid after reset", out_valid, 0);
        cmp("R1 out_hit after reset", out_hit, 0);
        cmp("R1 out_did after reset", out_did, 0);
        look(8'h00, 1'b1, 1'b1);
        cmp("R1 first lookup misses", out_hit, 0);
        cmp("R8 miss did", out_did, 0);
        cmp("R8 miss priv", out_priv, 1);
        cmp("R8 miss sec", out_sec, 1);

        // Descriptor set for the table walk
        put_desc(0, 1'b1, 8'hA0, 8'h0F, 4'd3,  2'b11, 2'b10, 1'b0);
        put_desc(1, 1'b1, 8'hA5, 8'h00, 4'd5,  2'b10, 2'b11, 1'b0);
        put_desc(2, 1'b0, 8'h30, 8'h00, 4'd7,  2'b11, 2'b11, 1'b0);
        put_desc(3, 1'b1, 8'h40, 8'hF0, 4'd9,  2'b00, 2'b01, 1'b0);
        put_desc(4, 1'b1, 8'h81, 8'h01, 4'd12, 2'b11, 2'b11, 1'b0);

        // R2 R3 R4 R5 R6 R7 R8 table walk
        for (int k = 0; k < NVEC; k++) begin
            look(VEC[k][16:9], VEC[k][8], VEC[k][7]);
            cmp($sformatf("R3 R4 hit vec%0d", k), out_hit, VEC[k][6]);
            cmp($sformatf("R5 did vec%0d", k), out_did, VEC[k][5:2]);
            cmp($sformatf("R6 priv vec%0d", k), out_priv, VEC[k][1]);
            cmp($sformatf("R7 sec vec%0d", k), out_sec, VEC[k][0]);
        end

        // R9 latency and hold
        cmp("R9 out_valid one cycle after request", out_valid, 1);
        @(negedge clk);
        cmp("R9 out_valid drops", out_valid, 0);
        cmp("R9 did held while idle", out_did, 9);

        // R4 R6 R7: disable entry 0, entry 1 now wins for 0xA5
        put_desc(0, 1'b0, 8'hA0, 8'h0F, 4'd3, 2'b11, 2'b10, 1'b0);
        look(8'hA5, 1'b1, 1'b0);
        cmp("R4 next index wins", out_did, 5);
        cmp("R6 forced user", out_priv, 0);
        cmp("R7 forced secure", out_sec, 1);

        // R10 lock
        put_desc(5, 1'b1, 8'h55, 8'h00, 4'd6, 2'b00, 2'b00, 1'b1);
        look(8'h55, 1'b0, 1'b0);
        cmp("R10 locked write stored", out_did, 6);
        put_desc(5, 1'b1, 8'h55, 8'h00, 4'd2, 2'b00, 2'b00, 1'b0);
        look(8'h55, 1'b0, 1'b0);
        cmp("R10 write to locked entry ignored", out_did, 6);
        put_desc(5, 1'b0, 8'h55, 8'h00, 4'd2, 2'b00, 2'b00, 1'b0);
        look(8'h55, 1'b0, 1'b0);
        cmp("R10 disable on locked entry ignored", out_hit, 1);

        // R11 write and lookup in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd6; cfg_valid = 1'b1; cfg_match = 8'h66; cfg_mask = 8'h00;
        cfg_did = 4'd4; cfg_priv_mode = 2'b00; cfg_sec_mode = 2'b00; cfg_lock = 1'b0;
        req_valid = 1'b1; req_id = 8'h66; req_priv = 1'b0; req_sec = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        cmp("R11 same-cycle lookup sees old contents", out_hit, 0);
        look(8'h66, 1'b0, 1'b0);
        cmp("R11 later lookup sees new contents hit", out_hit, 1);
        cmp("R11 later lookup did", out_did, 4);

        // R1 R10 reset clears the lock
        do_reset();
        look(8'h55, 1'b0, 1'b0);
        cmp("R1 entries disabled after reset", out_hit, 0);
        put_desc(5, 1'b1, 8'h55, 8'h00, 4'd2, 2'b00, 2'b00, 1'b0);
        look(8'h55, 1'b0, 1'b0);
        cmp("R10 lock cleared by reset", out_did, 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule